// File: doc/BRIEF.md
# Three-level carrier PWM modulator

This block drives the twelve gate signals of a three-phase, three-level neutral-point-clamped inverter. One up/down counter makes a triangular carrier. The counter value is the upper carrier, which runs from 0 to the period. The counter value minus the period is the lower carrier, which runs from minus the period to 0. Both carriers therefore have the same shape and frequency and sit in adjacent bands. Each phase reference is compared against both carriers.

A reference above the upper carrier puts the leg on the positive rail. A reference below the lower carrier puts it on the negative rail. Any other reference puts it on the neutral point. Each leg state is then decoded into four gate signals that form two complementary pairs.

References are taken in through a sample strobe and held in a pending register. The compare value is replaced only when the carrier turns at its peak or its valley, so it stays constant within each half period. The switching frequency equals the carrier frequency: one full carrier period lasts twice the period value in clocks.

Top module: `tlpwm_modulator`

## Requirements
- R1: While `rst_n` is low, all twelve gate outputs are 0 and every leg state output reads neutral (2'b00).
- R2: The counter runs 0,1,...,P,P-1,...,1,0, so one carrier period lasts 2P clocks. The period value P is taken from `period_i` only when the counter is 0. Values below 2 are used as 2.
- R3: A leg reads +1, encoded 2'b01, when its compare value is greater than the counter.
- R4: A leg reads -1, encoded 2'b11, when its compare value is below the counter minus P. Otherwise it reads 0, encoded 2'b00. Over one carrier period, a constant compare value r gives 2|r|-1 clocks at ±1 for 1<=|r|<=P and 2P clocks for |r|>P.
- R5: Within a leg's 4-bit gate group, bit 0 is the upper outer switch, bit 1 the upper inner, bit 2 the lower inner and bit 3 the lower outer. The state +1 gives 4'b0011, 0 gives 4'b0110 and -1 gives 4'b1100. The gate groups for phases a, b and c are bits [3:0], [7:4] and [11:8].
- R6: Out of reset, bit 0 is always the inverse of bit 2 and bit 1 is always the inverse of bit 3 in every gate group.
- R7: A reference input is captured only in a cycle where `ref_stb_i` is high. The captured value becomes the compare value only at a counter peak or valley. Reference changes without a strobe have no effect.
- R8: A leg never moves directly between +1 and -1. Such a swing shows exactly one clock of 0 between the two states.
- R9: The leg state is registered. A compare value that takes effect at a peak shows at the outputs two clocks after the peak cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_i | input | CNT_W | Carrier half period in clocks |
| ref_stb_i | input | 1 | Capture strobe for the three references |
| ref_a_i | input | REF_W | Signed reference, phase a |
| ref_b_i | input | REF_W | Signed reference, phase b |
| ref_c_i | input | REF_W | Signed reference, phase c |
| gate_o | output | 12 | Gate signals, four per phase |
| leg_a_o | output | 2 | Leg state, phase a |
| leg_b_o | output | 2 | Leg state, phase b |
| leg_c_o | output | 2 | Leg state, phase c |

## Verification
The bench builds the block with CNT_W=6 and REF_W=8 and runs mostly with a period of 8. A full carrier period is then only 16 clocks, so duty counts can be taken over exact periods. With 8-bit references, values beyond ±P that saturate a leg are easy to reach. The bench also drives periods of 4, 1 and 0, which reach the period reload at the valley and the floor of 2. A reference of 1 gives a one-clock pulse at each valley. That pulse aligns the bench to the carrier, so the bench can time the peak-only sampling and the output latency exactly.

// File: rtl/tlpwm_pkg.sv
package tlpwm_pkg;

  localparam int NUM_LEGS      = 3;
  localparam int GATES_PER_LEG = 4;
  localparam int MIN_PERIOD    = 2;

  typedef enum logic [1:0] {
    LEG_ZERO = 2'b00,
    LEG_POS  = 2'b01,
    LEG_NEG  = 2'b11
  } leg_state_e;

  // Compare one reference against the upper carrier (counter) and the
  // lower carrier (counter minus period).
  function automatic leg_state_e classify(input int ref_v, input int cnt_v, input int per_v);
    leg_state_e res;
    if (ref_v > cnt_v)              res = LEG_POS;
    else if (ref_v < cnt_v - per_v) res = LEG_NEG;
    else                            res = LEG_ZERO;
    return res;
  endfunction

  // A full rail-to-rail swing is broken by one neutral cycle.
  function automatic leg_state_e neutral_transit(input leg_state_e prev, input leg_state_e want);
    leg_state_e res;
    if ((prev == LEG_POS && want == LEG_NEG) || (prev == LEG_NEG && want == LEG_POS))
      res = LEG_ZERO;
    else
      res = want;
    return res;
  endfunction

  // Gate nibble: [0] upper outer, [1] upper inner, [2] lower inner, [3] lower outer.
  function automatic logic [GATES_PER_LEG-1:0] gates_of(input leg_state_e s);
    logic [GATES_PER_LEG-1:0] g;
    case (s)
      LEG_POS:  g = 4'b0011;
      LEG_NEG:  g = 4'b1100;
      default:  g = 4'b0110;
    endcase
    return g;
  endfunction

  function automatic int floor_period(input int p);
    return (p < MIN_PERIOD) ? MIN_PERIOD : p;
  endfunction

endpackage

// File: rtl/tlpwm_carrier.sv
module tlpwm_carrier
  import tlpwm_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] per_o,
  output logic             turn_o
);

  localparam logic [CNT_W-1:0] PER_RESET = CNT_W'(MIN_PERIOD);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] per_q;
  logic             up_q;
  logic             at_valley;
  logic             at_peak;
  logic             up_eff;

  assign at_valley = (cnt_q == '0);
  assign at_peak   = (cnt_q == per_q);
  assign up_eff    = at_valley | (up_q & ~at_peak);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= PER_RESET;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= up_eff ? cnt_q + CNT_W'(1) : cnt_q - CNT_W'(1);
      up_q  <= up_eff;
      if (at_valley)
        per_q <= CNT_W'(floor_period(int'(period_i)));
    end
  end

  assign cnt_o  = cnt_q;
  assign per_o  = per_q;
  assign turn_o = at_valley | at_peak;

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= per_q); // R2
  AST_PERIOD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n) per_q >= PER_RESET); // R2
  AST_PERIOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !at_valley |=> $stable(per_q)); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> (cnt_q == $past(cnt_q) + CNT_W'(1)) || (cnt_q == $past(cnt_q) - CNT_W'(1))); // R2

endmodule

// File: rtl/tlpwm_gate_decode.sv
module tlpwm_gate_decode
  import tlpwm_pkg::*;
(
  input  leg_state_e               state_i,
  input  logic                     en_i,
  output logic [GATES_PER_LEG-1:0] gates_o
);

  always_comb begin
    gates_o = en_i ? gates_of(state_i) : '0;
    if (en_i) begin
      AST_PAIR_COMPLEMENT: assert (gates_o[0] != gates_o[2] && gates_o[1] != gates_o[3]); // R6
    end
  end

endmodule

// File: rtl/tlpwm_leg.sv
module tlpwm_leg
  import tlpwm_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int REF_W = 14
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     gate_en_i,
  input  logic signed [REF_W-1:0]  ref_i,
  input  logic                     ref_stb_i,
  input  logic [CNT_W-1:0]         cnt_i,
  input  logic [CNT_W-1:0]         per_i,
  input  logic                     turn_i,
  output logic [1:0]               state_o,
  output logic [GATES_PER_LEG-1:0] gates_o
);

  logic signed [REF_W-1:0] pend_q;
  logic signed [REF_W-1:0] act_q;
  leg_state_e              state_q;
  leg_state_e              raw_state;
  leg_state_e              next_state;

  assign raw_state  = classify(int'(act_q), int'(cnt_i), int'(per_i));
  assign next_state = neutral_transit(state_q, raw_state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      act_q   <= '0;
      state_q <= LEG_ZERO;
    end else begin
      if (ref_stb_i) pend_q <= ref_i;
      if (turn_i)    act_q  <= pend_q;
      state_q <= next_state;
    end
  end

  tlpwm_gate_decode u_decode (
    .state_i (state_q),
    .en_i    (gate_en_i),
    .gates_o (gates_o)
  );

  assign state_o = state_q;

  AST_NO_SWING_DOWN: assert property (@(posedge clk) disable iff (!rst_n) (state_q == LEG_POS) |=> (state_q != LEG_NEG)); // R8
  AST_NO_SWING_UP: assert property (@(posedge clk) disable iff (!rst_n) (state_q == LEG_NEG) |=> (state_q != LEG_POS)); // R8
  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !turn_i |=> $stable(act_q)); // R7
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !ref_stb_i |=> $stable(pend_q)); // R7

endmodule

// File: rtl/tlpwm_modulator.sv
module tlpwm_modulator
  import tlpwm_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int REF_W = 14
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [CNT_W-1:0]                    period_i,
  input  logic                                ref_stb_i,
  input  logic signed [REF_W-1:0]             ref_a_i,
  input  logic signed [REF_W-1:0]             ref_b_i,
  input  logic signed [REF_W-1:0]             ref_c_i,
  output logic [NUM_LEGS*GATES_PER_LEG-1:0]   gate_o,
  output logic [1:0]                          leg_a_o,
  output logic [1:0]                          leg_b_o,
  output logic [1:0]                          leg_c_o
);

  logic [CNT_W-1:0]        cnt;
  logic [CNT_W-1:0]        per;
  logic                    turn;
  logic                    gate_en_q;
  logic                    gate_en;
  logic signed [REF_W-1:0] ref_arr [NUM_LEGS];
  logic [1:0]              leg_arr [NUM_LEGS];

  tlpwm_carrier #(.CNT_W(CNT_W)) u_carrier (
    .clk      (clk),
    .rst_n    (rst_n),
    .period_i (period_i),
    .cnt_o    (cnt),
    .per_o    (per),
    .turn_o   (turn)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_en_q <= 1'b0;
    else        gate_en_q <= 1'b1;
  end

  assign gate_en = rst_n & gate_en_q;

  assign ref_arr[0] = ref_a_i;
  assign ref_arr[1] = ref_b_i;
  assign ref_arr[2] = ref_c_i;

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    tlpwm_leg #(.CNT_W(CNT_W), .REF_W(REF_W)) u_leg (
      .clk       (clk),
      .rst_n     (rst_n),
      .gate_en_i (gate_en),
      .ref_i     (ref_arr[g]),
      .ref_stb_i (ref_stb_i),
      .cnt_i     (cnt),
      .per_i     (per),
      .turn_i    (turn),
      .state_o   (leg_arr[g]),
      .gates_o   (gate_o[g*GATES_PER_LEG +: GATES_PER_LEG])
    );
  end

  assign leg_a_o = leg_arr[0];
  assign leg_b_o = leg_arr[1];
  assign leg_c_o = leg_arr[2];

  always_comb begin
    if (!rst_n) begin
      AST_GATES_OFF_RESET: assert (gate_o == '0); // R1
    end
  end

endmodule

// File: tb/tlpwm_modulator_bench.sv
module tlpwm_modulator_bench;

  localparam int CNT_W = 6;
  localparam int REF_W = 8;
  localparam int HALF  = 10;        // 20-unit period: 50 MHz at 1 ns units
  localparam int WATCHDOG = 20000;
  localparam int NV = 9;
  localparam int TBL_REF [NV] = '{0, 1, 3, 8, 9, -1, -5, -8, -9};
  localparam int TBL_POS [NV] = '{0, 1, 5, 15, 16, 0, 0, 0, 0};
  localparam int TBL_NEG [NV] = '{0, 0, 0, 0, 0, 1, 9, 15, 16};

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic [CNT_W-1:0]        period_i = 6'd8;
  logic                    ref_stb_i = 1'b0;
  logic signed [REF_W-1:0] ref_a_i = '0;
  logic signed [REF_W-1:0] ref_b_i = '0;
  logic signed [REF_W-1:0] ref_c_i = '0;
  logic [11:0]             gate_o;
  logic [1:0]              leg_a_o, leg_b_o, leg_c_o;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  tlpwm_modulator #(.CNT_W(CNT_W), .REF_W(REF_W)) u_tlpwm_modulator (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .ref_stb_i(ref_stb_i),
    .ref_a_i(ref_a_i), .ref_b_i(ref_b_i), .ref_c_i(ref_c_i),
    .gate_o(gate_o), .leg_a_o(leg_a_o), .leg_b_o(leg_b_o), .leg_c_o(leg_c_o)
  );

  always #HALF clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] expect_gates(input logic [1:0] s);
    if (s == 2'b01) return 4'b0011;
    if (s == 2'b11) return 4'b1100;
    return 4'b0110;
  endfunction

  function automatic bit group_ok(input logic [1:0] s, input logic [3:0] g);
    return (g == expect_gates(s)) && (g[0] != g[2]) && (g[1] != g[3]);
  endfunction

  task automatic strobe(input int ra, input int rb, input int rc);
    @(negedge clk);
    ref_a_i = REF_W'(ra); ref_b_i = REF_W'(rb); ref_c_i = REF_W'(rc);
    ref_stb_i = 1'b1;
    @(negedge clk);
    ref_stb_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_pulse_a(output bit found);
    found = 1'b0;
    for (int i = 0; i < 100 && !found; i++) begin
      @(negedge clk);
      if (leg_a_o == 2'b01) found = 1'b1;
    end
  endtask

  task automatic gap_a(output int gap);
    gap = -1;
    for (int i = 1; i <= 100 && gap < 0; i++) begin
      @(negedge clk);
      if (leg_a_o == 2'b01) gap = i;
    end
  endtask

  // count clocks per state over one 16-clock carrier period (P = 8)
  task automatic window(output int ap, output int an, output int bp, output int bn,
                        output int cnz, output int bad);
    ap = 0; an = 0; bp = 0; bn = 0; cnz = 0; bad = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (leg_a_o == 2'b01) ap++;
      if (leg_a_o == 2'b11) an++;
      if (leg_b_o == 2'b01) bp++;
      if (leg_b_o == 2'b11) bn++;
      if (leg_c_o != 2'b00) cnz++;
      if (!group_ok(leg_a_o, gate_o[3:0]) || !group_ok(leg_b_o, gate_o[7:4]) ||
          !group_ok(leg_c_o, gate_o[11:8])) bad++;
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    int ap, an, bp, bn, cnz, bad, gap, zeros, direct;
    bit found;
    logic [1:0] prev;

    // R1: reset state
    idle(3);
    check(gate_o == 12'd0, "R1 gates off in reset", int'(gate_o), 0);
    check({leg_a_o, leg_b_o, leg_c_o} == 6'd0, "R1 legs neutral in reset",
          int'({leg_a_o, leg_b_o, leg_c_o}), 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    check(gate_o == 12'h666, "R5 all-neutral gate pattern", int'(gate_o), 12'h666);

    // R3 R4 R5 R6: duty table, phase b mirrored, phase c neutral
    for (int k = 0; k < NV; k++) begin
      strobe(TBL_REF[k], -TBL_REF[k], 0);
      idle(40);
      window(ap, an, bp, bn, cnz, bad);
      check(ap == TBL_POS[k], "R3 phase a +1 clocks", ap, TBL_POS[k]);
      check(an == TBL_NEG[k], "R4 phase a -1 clocks", an, TBL_NEG[k]);
      check(bp == TBL_NEG[k], "R3 phase b +1 clocks", bp, TBL_NEG[k]);
      check(bn == TBL_POS[k], "R4 phase b -1 clocks", bn, TBL_POS[k]);
      check(cnz == 0, "R4 phase c neutral clocks off zero", cnz, 0);
      check(bad == 0, "R5 R6 gate groups mismatching", bad, 0);
    end

    // R7: reference change without strobe is ignored
    strobe(3, 0, 0);
    idle(40);
    @(negedge clk); ref_a_i = 8'sd8;
    idle(40);
    window(ap, an, bp, bn, cnz, bad);
    check(ap == 5, "R7 unstrobed change ignored", ap, 5);

    // R7 R9: peak-only sampling and latency, aligned on the valley pulse
    strobe(1, 0, 0);
    idle(40);
    wait_pulse_a(found);
    check(found, "R9 valley pulse seen", int'(found), 1);
    ref_a_i = 8'sd9; ref_stb_i = 1'b1;
    @(negedge clk); ref_stb_i = 1'b0;
    zeros = (leg_a_o == 2'b00) ? 1 : 0;
    for (int i = 2; i <= 8; i++) begin
      @(negedge clk);
      if (leg_a_o == 2'b00) zeros++;
    end
    check(zeros == 8, "R7 old value held until peak", zeros, 8);
    @(negedge clk);
    check(leg_a_o == 2'b01, "R9 new value two clocks after peak", int'(leg_a_o), 1);

    // R2: period reload at valley only, then floor of 2
    strobe(1, 0, 0);
    idle(40);
    wait_pulse_a(found);
    period_i = 6'd4;
    gap_a(gap);
    check(gap == 16, "R2 old period kept until valley", gap, 16);
    gap_a(gap);
    check(gap == 8, "R2 new period 4", gap, 8);
    period_i = 6'd1;
    gap_a(gap); gap_a(gap);
    check(gap == 4, "R2 period 1 floored to 2", gap, 4);
    period_i = 6'd0;
    gap_a(gap); gap_a(gap);
    check(gap == 4, "R2 period 0 floored to 2", gap, 4);
    period_i = 6'd8;
    gap_a(gap); gap_a(gap);
    check(gap == 16, "R2 period 8 restored", gap, 16);

    // R8: rail-to-rail swing passes one neutral clock, both directions
    for (int d = 0; d < 2; d++) begin
      strobe(d == 0 ? 9 : -9, 0, 0);
      idle(40);
      prev = leg_a_o;
      zeros = 0; direct = 0;
      strobe(d == 0 ? -9 : 9, 0, 0);
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (leg_a_o == 2'b00) zeros++;
        if ((prev == 2'b01 && leg_a_o == 2'b11) || (prev == 2'b11 && leg_a_o == 2'b01)) direct++;
        prev = leg_a_o;
      end
      check(direct == 0, "R8 direct swings", direct, 0);
      check(zeros == 1, "R8 neutral clocks in swing", zeros, 1);
      check(leg_a_o == (d == 0 ? 2'b11 : 2'b01), "R8 final rail", int'(leg_a_o),
            d == 0 ? 3 : 1);
    end

    // R1: reset asserted mid-run forces gates off
    @(negedge clk); rst_n = 1'b0;
    #1;
    check(gate_o == 12'd0, "R1 gates off on mid-run reset", int'(gate_o), 0);
    idle(2);
    check(leg_a_o == 2'b00, "R1 leg neutral on mid-run reset", int'(leg_a_o), 0);
    rst_n = 1'b1;
    idle(2);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule